// File: doc/BRIEF.md
# Invalid-Tag Tracker with Speculative Store Cache

This block sits beside the leading core of a paired-core arrangement. That core keeps running past long memory misses instead of waiting for them. The block keeps one poison bit for each physical register. A load that misses the last-level cache does not stall. Instead its destination register is marked as holding a placeholder (zero) value. Any instruction that reads a marked register passes the mark on to its own destination.

Stores that retire in this mode never reach the data cache. Each one writes a small direct-mapped speculative store cache. Later loads look in that cache first. A load that hits takes the stored data, or the stored poison mark, and ignores any last-level miss it carries. A load that misses the cache falls through to the normal memory path. A recovery flush clears every poison bit and every cache entry in one cycle.

A two-state mode machine tracks whether any poison is live:
- **CLEAN**: no register is poisoned, so source lookups are skipped and the source term is forced to zero. It moves to **TAINTED** on *poison-set*, which is an issued instruction with a poisoned result and no flush in the same cycle.
- **TAINTED**: at least one register may be poisoned. It returns to CLEAN on *flush*. It also returns to CLEAN on *drain*, which is a cycle in which no bit is set and no new poison is written.

Top module: `itrc_invalid_tracker`

## Requirements
- R1: After reset, no register reads as poisoned, and a lookup at any address reports no hit and zero data.
- R2: An issued load that misses the speculative cache and has `iss_l2_miss` set raises `iss_dst_inv` and poisons its destination from the next cycle.
- R3: `iss_dst_inv` is the OR of the poison bits of all sources together with the load term. An issued instruction writes that value into its destination's bit, so a clean result clears a stale mark. The outputs follow the current inputs even when `iss_valid` is low, but state changes only when it is high.
- R4: A retiring store writes the cache entry at index `addr[3:0]`, with tag `addr[15:4]`, its data and its invalid flag. A store never changes any register's poison bit.
- R5: A load that hits a clean entry gives `ld_hit`=1 and that entry's data, and its result is clean even when `iss_l2_miss` is set. A load that hits an invalid entry gives `ld_hit`=1, data zero and a poisoned result.
- R6: A load whose tag differs from the tag stored at its index, or whose index is empty, gives `ld_hit`=0 and data zero. Its result then follows `iss_l2_miss`.
- R7: `flush` clears all poison bits and all cache entries at the next edge. An issue, free or store in the same cycle has no effect.
- R8: `free_valid` clears the poison bit of `free_preg`. If the same register is also an issued destination in that cycle, the issued value wins.
- R9: A store to an occupied index replaces the old entry, so the old address then misses.
- R10: A lookup sees the cache as it stood before any store retiring in the same cycle. The new store is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Recovery: clear all poison and cache entries |
| iss_valid | input | 1 | Issue slot carries an instruction |
| iss_src | input | NUM_SRC*PW | Source physical registers, source 0 in the low bits |
| iss_dst | input | PW | Destination physical register |
| iss_load | input | 1 | Issued instruction is a load |
| iss_addr | input | ADDR_W | Load word address |
| iss_l2_miss | input | 1 | Load missed the last-level cache |
| iss_dst_inv | output | 1 | Poison value computed for the destination |
| ld_hit | output | 1 | Load hit the speculative store cache |
| ld_data | output | DATA_W | Data from the speculative cache, or zero |
| ret_valid | input | 1 | Retire slot carries an instruction |
| ret_store | input | 1 | Retiring instruction is a store |
| ret_addr | input | ADDR_W | Store word address |
| ret_data | input | DATA_W | Store data |
| ret_inv | input | 1 | Store address or data is poisoned |
| free_valid | input | 1 | Release a physical register |
| free_preg | input | PW | Register being released |

## Verification
The assertions check on every cycle that CLEAN never coexists with a live poison bit. They also check that every register write, release and store lands in state at the next edge, and that a flush leaves the register bits and the cache valid bits all zero. Only the bench's scenarios can show the full end-to-end behaviour:
- poison carried through chains of dependent instructions;
- a cache hit overriding a last-level miss;
- a tag mismatch falling through;
- eviction by a later store;
- the ordering of a lookup and a store in the same cycle;
- a flush blocking an issue and a store in its own cycle.

// File: rtl/itrc_pkg.sv
package itrc_pkg;
    typedef enum logic [0:0] {
        MODE_CLEAN   = 1'b0,
        MODE_TAINTED = 1'b1
    } mode_e;
endpackage

// File: rtl/itrc_poison_file.sv
module itrc_poison_file #(
    parameter int NUM_PREGS = 32,
    parameter int NUM_SRC   = 2,
    localparam int PW       = $clog2(NUM_PREGS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush,
    input  logic                  lookup_off,
    input  logic [NUM_SRC*PW-1:0] src_flat,
    input  logic                  wr_en,
    input  logic [PW-1:0]         wr_preg,
    input  logic                  wr_inv,
    input  logic                  free_en,
    input  logic [PW-1:0]         free_preg,
    output logic                  src_inv,
    output logic                  any_inv
);
    logic [NUM_PREGS-1:0] poison_q;
    logic [NUM_SRC-1:0]   src_hit;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign src_hit[g] = poison_q[src_flat[g*PW +: PW]];
    end

    assign src_inv = !lookup_off && (|src_hit);
    assign any_inv = |poison_q;

    // release first, issue write second: issue wins on the same register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            poison_q <= '0;
        end else if (flush) begin
            poison_q <= '0;
        end else begin
            if (free_en) poison_q[free_preg] <= 1'b0;
            if (wr_en)   poison_q[wr_preg]   <= wr_inv;
        end
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !flush |=> poison_q[$past(wr_preg)] == $past(wr_inv)); // R2
    AST_FREE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        free_en && !flush && !(wr_en && wr_preg == free_preg) |=> !poison_q[$past(free_preg)]); // R8
    AST_FLUSH_POISON: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> poison_q == '0); // R7
endmodule

// File: rtl/itrc_ra_cache.sv
module itrc_ra_cache #(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int TAG_W  = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic              lk_inv,
    output logic [DATA_W-1:0] lk_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_inv
);
    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] inv_q;
    logic [TAG_W-1:0]   tag_q  [ENTRIES];
    logic [DATA_W-1:0]  data_q [ENTRIES];

    logic [IDX_W-1:0] lk_idx, wr_idx;
    logic [TAG_W-1:0] lk_tag, wr_tag;

    assign lk_idx = lk_addr[IDX_W-1:0];
    assign lk_tag = lk_addr[ADDR_W-1:IDX_W];
    assign wr_idx = wr_addr[IDX_W-1:0];
    assign wr_tag = wr_addr[ADDR_W-1:IDX_W];

    always_comb begin
        lk_hit  = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
        lk_inv  = lk_hit && inv_q[lk_idx];
        lk_data = (lk_hit && !inv_q[lk_idx]) ? data_q[lk_idx] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            inv_q   <= '0;
        end else if (flush) begin
            valid_q <= '0;
            inv_q   <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
            inv_q[wr_idx]   <= wr_inv;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !flush) begin
            tag_q[wr_idx]  <= wr_tag;
            data_q[wr_idx] <= wr_data;
        end
    end

    AST_STORE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !flush |=> valid_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag)); // R4
    AST_FLUSH_CACHE: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> valid_q == '0); // R7
endmodule

// File: rtl/itrc_invalid_tracker.sv
module itrc_invalid_tracker
    import itrc_pkg::*;
#(
    parameter int NUM_PREGS  = 32,
    parameter int NUM_SRC    = 2,
    parameter int RC_ENTRIES = 16,
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    localparam int PW        = $clog2(NUM_PREGS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush,
    input  logic                  iss_valid,
    input  logic [NUM_SRC*PW-1:0] iss_src,
    input  logic [PW-1:0]         iss_dst,
    input  logic                  iss_load,
    input  logic [ADDR_W-1:0]     iss_addr,
    input  logic                  iss_l2_miss,
    output logic                  iss_dst_inv,
    output logic                  ld_hit,
    output logic [DATA_W-1:0]     ld_data,
    input  logic                  ret_valid,
    input  logic                  ret_store,
    input  logic [ADDR_W-1:0]     ret_addr,
    input  logic [DATA_W-1:0]     ret_data,
    input  logic                  ret_inv,
    input  logic                  free_valid,
    input  logic [PW-1:0]         free_preg
);
    mode_e             mode_q, mode_d;
    logic              lookup_off;
    logic              src_inv, any_inv;
    logic              c_hit, c_inv;
    logic [DATA_W-1:0] c_data;
    logic              load_term, set_evt;

    itrc_poison_file #(.NUM_PREGS(NUM_PREGS), .NUM_SRC(NUM_SRC)) u_pf (
        .clk(clk), .rst_n(rst_n), .flush(flush), .lookup_off(lookup_off),
        .src_flat(iss_src), .wr_en(iss_valid), .wr_preg(iss_dst),
        .wr_inv(iss_dst_inv), .free_en(free_valid), .free_preg(free_preg),
        .src_inv(src_inv), .any_inv(any_inv)
    );

    itrc_ra_cache #(.ENTRIES(RC_ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rc (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_addr(iss_addr), .lk_hit(c_hit), .lk_inv(c_inv), .lk_data(c_data),
        .wr_en(ret_valid && ret_store), .wr_addr(ret_addr),
        .wr_data(ret_data), .wr_inv(ret_inv)
    );

    assign load_term   = iss_load && (c_hit ? c_inv : iss_l2_miss);
    assign iss_dst_inv = src_inv || load_term;
    assign ld_hit      = iss_load && c_hit;
    assign ld_data     = iss_load ? c_data : '0;
    assign set_evt     = iss_valid && iss_dst_inv && !flush;

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_CLEAN;
        else        mode_q <= mode_d;
    end

    always_comb begin
        mode_d     = mode_q;
        lookup_off = 1'b0;
        unique case (mode_q)
            MODE_CLEAN: begin
                lookup_off = 1'b1;
                if (set_evt) mode_d = MODE_TAINTED;
            end
            MODE_TAINTED: begin
                if (flush)                      mode_d = MODE_CLEAN;
                else if (!any_inv && !set_evt)  mode_d = MODE_CLEAN;
            end
            default: mode_d = MODE_CLEAN;
        endcase
    end

    AST_CLEAN_NO_POISON: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q == MODE_CLEAN |-> !any_inv); // R3
    AST_SET_TAINTS: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> mode_q == MODE_TAINTED); // R2
endmodule

// File: tb/sim_itrc_invalid_tracker.sv
`timescale 1ns/100ps
module sim_itrc_invalid_tracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        iss_valid = 1'b0;
    logic [9:0]  iss_src = '0;
    logic [4:0]  iss_dst = '0;
    logic        iss_load = 1'b0;
    logic [15:0] iss_addr = '0;
    logic        iss_l2_miss = 1'b0;
    logic        iss_dst_inv;
    logic        ld_hit;
    logic [31:0] ld_data;
    logic        ret_valid = 1'b0;
    logic        ret_store = 1'b0;
    logic [15:0] ret_addr = '0;
    logic [31:0] ret_data = '0;
    logic        ret_inv = 1'b0;
    logic        free_valid = 1'b0;
    logic [4:0]  free_preg = '0;

    int n_chk = 0;
    int n_bad = 0;

    bit          mp [32];
    bit          mv [16];
    bit          mi [16];
    logic [11:0] mtag [16];
    logic [31:0] mdat [16];

    always #2.5 clk = ~clk;

    itrc_invalid_tracker u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush), .iss_valid(iss_valid),
        .iss_src(iss_src), .iss_dst(iss_dst), .iss_load(iss_load),
        .iss_addr(iss_addr), .iss_l2_miss(iss_l2_miss), .iss_dst_inv(iss_dst_inv),
        .ld_hit(ld_hit), .ld_data(ld_data), .ret_valid(ret_valid),
        .ret_store(ret_store), .ret_addr(ret_addr), .ret_data(ret_data),
        .ret_inv(ret_inv), .free_valid(free_valid), .free_preg(free_preg)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic idle();
        flush = 0; iss_valid = 0; iss_src = '0; iss_dst = '0; iss_load = 0;
        iss_addr = '0; iss_l2_miss = 0; ret_valid = 0; ret_store = 0;
        ret_addr = '0; ret_data = '0; ret_inv = 0; free_valid = 0; free_preg = '0;
    endtask

    // inputs already driven after a falling edge; check, clock, update model
    task automatic tick(input string req);
        logic [3:0]  ix;
        logic [11:0] tg;
        bit          hit, ei;
        logic [31:0] ed;
        ix  = iss_addr[3:0];
        tg  = iss_addr[15:4];
        hit = iss_load && mv[ix] && (mtag[ix] == tg);
        ei  = mp[iss_src[4:0]] | mp[iss_src[9:5]] | (iss_load && (hit ? mi[ix] : iss_l2_miss));
        ed  = (hit && !mi[ix]) ? mdat[ix] : 32'h0;
        #1;
        check(iss_dst_inv == ei, {req, " dst_inv"}, {31'h0, iss_dst_inv}, {31'h0, ei});
        if (iss_load) begin
            check(ld_hit == hit, {req, " ld_hit"}, {31'h0, ld_hit}, {31'h0, hit});
            check(ld_data == ed, {req, " ld_data"}, ld_data, ed);
        end
        @(negedge clk);
        if (flush) begin
            foreach (mp[i]) mp[i] = 0;
            foreach (mv[i]) begin mv[i] = 0; mi[i] = 0; end
        end else begin
            if (free_valid) mp[free_preg] = 0;
            if (iss_valid)  mp[iss_dst] = ei;
            if (ret_valid && ret_store) begin
                mv[ret_addr[3:0]]   = 1;
                mi[ret_addr[3:0]]   = ret_inv;
                mtag[ret_addr[3:0]] = ret_addr[15:4];
                mdat[ret_addr[3:0]] = ret_data;
            end
        end
    endtask

    task automatic probe(input int r, input string req);
        idle();
        iss_src = {r[4:0], r[4:0]};
        tick(req);
    endtask

    task automatic probe_all(input string req);
        for (int r = 0; r < 32; r++) probe(r, req);
    endtask

    task automatic load(input int d, input logic [15:0] a, input bit miss, input bit v, input string req);
        idle();
        iss_valid = v; iss_load = 1; iss_dst = d[4:0]; iss_addr = a; iss_l2_miss = miss;
        iss_src = {5'd31, 5'd31};
        tick(req);
    endtask

    task automatic store(input logic [15:0] a, input logic [31:0] dat, input bit inv, input string req);
        idle();
        ret_valid = 1; ret_store = 1; ret_addr = a; ret_data = dat; ret_inv = inv;
        tick(req);
    endtask

    function automatic logic [15:0] addr_of(input int ix, input int t);
        return {t[11:0], ix[3:0]};
    endfunction

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle();
        foreach (mp[i]) mp[i] = 0;
        foreach (mv[i]) begin mv[i] = 0; mi[i] = 0; mtag[i] = '0; mdat[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state
        probe_all("R1 reset poison");
        for (int ix = 0; ix < 16; ix++) load(0, addr_of(ix, ix + 2), 0, 0, "R1 reset lookup");

        // R2: misses poison each destination (reg 31 stays as a clean source)
        for (int r = 0; r < 31; r++) load(r, addr_of(r % 16, 100 + r), 1, 1, "R2 miss poisons");
        probe_all("R2 poison visible");
        // R3: outputs follow inputs with iss_valid low, but state does not move
        load(31, addr_of(3, 900), 1, 0, "R3 invalid slot no write");
        probe(31, "R3 invalid slot no write");

        // R8: release odd registers
        for (int r = 1; r < 31; r += 2) begin
            idle(); free_valid = 1; free_preg = r[4:0]; tick("R8 free clears");
        end
        probe_all("R8 after free");

        // R3: dependency sweep over sources, results into registers 16..23
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++) begin
                idle(); iss_valid = 1; iss_src = {b[4:0], a[4:0]};
                iss_dst = 5'(16 + ((a + b) % 8)); tick("R3 propagate");
            end
        probe_all("R3 after sweep");

        // R8: free and issue hit the same register in one cycle
        idle(); iss_valid = 1; iss_src = {5'd0, 5'd0}; iss_dst = 5'd9;
        free_valid = 1; free_preg = 5'd9; tick("R8 issue wins");
        probe(9, "R8 issue wins");

        // R4: stores to every index; some poisoned
        for (int ix = 0; ix < 16; ix++)
            store(addr_of(ix, ix * 3 + 1), 32'hA000_0000 + ix * 17, (ix % 4) == 0, "R4 store");
        probe_all("R4 store leaves poison");
        // R5: hits, with miss flag set to show it is ignored
        for (int ix = 0; ix < 16; ix++) load(25, addr_of(ix, ix * 3 + 1), 1, 1, "R5 hit");
        probe(25, "R5 hit result");
        // R6: tag mismatch falls through
        for (int ix = 0; ix < 16; ix++) load(26, addr_of(ix, ix * 3 + 2), ix[0], 1, "R6 mismatch");
        probe(26, "R6 fallthrough result");

        // R9: eviction at index 5
        store(addr_of(5, 77), 32'h5555_0077, 0, "R9 evict store");
        load(27, addr_of(5, 16), 0, 1, "R9 old addr misses");
        load(27, addr_of(5, 77), 1, 1, "R9 new addr hits");

        // R10: same-cycle store and lookup at index 7
        idle();
        ret_valid = 1; ret_store = 1; ret_addr = addr_of(7, 22); ret_data = 32'h7777_0022;
        iss_load = 1; iss_addr = addr_of(7, 22); iss_dst = 5'd28; iss_valid = 1;
        iss_src = {5'd31, 5'd31};
        tick("R10 lookup before store");
        load(28, addr_of(7, 22), 1, 1, "R10 visible next cycle");

        // R7: flush with a poisoning issue, a release and a store in the same cycle
        idle();
        flush = 1; iss_valid = 1; iss_load = 1; iss_l2_miss = 1; iss_dst = 5'd31;
        iss_addr = addr_of(2, 40); free_valid = 1; free_preg = 5'd0;
        ret_valid = 1; ret_store = 1; ret_addr = addr_of(2, 40); ret_data = 32'hDEAD_0002;
        tick("R7 flush");
        probe_all("R7 poison cleared");
        for (int ix = 0; ix < 16; ix++) load(30, addr_of(ix, ix * 3 + 1), 0, 0, "R7 cache cleared");
        load(30, addr_of(2, 40), 0, 0, "R7 same-cycle store dropped");

        // back to operation after flush
        load(4, addr_of(1, 9), 1, 1, "R2 after flush");
        probe(4, "R2 after flush");

        idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule